// File: doc/BRIEF.md
# Framed serial packet receiver

This block sits behind a byte de-stuffer and parses HDLC-like frames from a stream of events. Each event is either a frame delimiter or one data byte. A frame opens with a delimiter and continues with a protocol byte, a sequence token byte, a payload and a two-byte frame check sequence (FCS). A closing delimiter ends it. Payload bytes go downstream on a valid/ready port. Every frame that ends, by completing or by being aborted, gives a one-cycle end-of-packet pulse with a pass/fail flag. A passing frame also presents its token on an acknowledgement port so that the transmit side can queue an acknowledgement.

Data bytes pass through a two-entry hold stage, so the two bytes before the closing delimiter are never forwarded and serve as the FCS. The block checks the FCS against a CRC-16 (polynomial `CRC_POLY`, initial value 0, no final inversion, MSB first). A delimiter that aborts a frame also opens the next one. An `enable` input lets the receiver drain into an inactive state without cutting a frame in half.

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset `rx_off` is 1, `pay_valid`, `eop_valid` and `ack_valid` are 0 and `ev_ready` is 1. With `enable` high the receiver leaves the inactive state on the next clock and enters no-sync. In no-sync, data events are consumed and produce no output.
- R2: A delimiter accepted in no-sync clears the CRC and byte counter and moves the receiver to wait for the protocol byte. Further delimiters in that wait state are ignored.
- R3: The protocol byte must equal `PROTO_ACKREQ` (default 8'h44). Any other value gives an end-of-packet failure, and the receiver returns to no-sync, where it waits for a delimiter.
- R4: A delimiter in place of the token byte gives an end-of-packet failure, and the next data byte is taken as a protocol byte.
- R5: A data byte after the token is forwarded on `pay_data` only when the second newer data byte is accepted, in arrival order. `pay_valid` rises on the clock that accepts that newer byte. The last two bytes before the closing delimiter are never forwarded.
- R6: The CRC covers the protocol byte, the token and every forwarded payload byte, and nothing else. The FCS reads the older held byte as bits 7:0 and the newer held byte as bits 15:8.
- R7: A frame passes when its closing delimiter arrives with at least two info bytes held and a matching FCS. On the clock that accepts the delimiter, `eop_valid`, `eop_ok` and `ack_valid` pulse for one cycle and `ack_token` carries the token. The receiver then returns to no-sync.
- R8: A closing delimiter that finds fewer than two info bytes, or an FCS mismatch, gives `eop_valid`=1 and `eop_ok`=0 with no acknowledgement. The next data byte is taken as a protocol byte.
- R9: At most `MTU` bytes are counted after the token. Any event accepted while the count equals `MTU` aborts with failure. If that event is a delimiter the receiver waits for a protocol byte, otherwise it goes to no-sync.
- R10: While `pay_valid`=1 and `pay_ready`=0, `ev_ready` is 0 and `pay_data` holds its value, so no byte is lost.
- R11: With `enable` low, the receiver becomes inactive at once from no-sync, or on the clock that ends the frame in progress. While inactive, events are consumed and ignored and no end-of-packet is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver run request; low drains to inactive |
| ev_valid | input | 1 | An input event is offered |
| ev_delim | input | 1 | The offered event is a frame delimiter |
| ev_byte | input | 8 | Data byte of the event (ignored for delimiters) |
| ev_ready | output | 1 | Event accepted on this clock when high with ev_valid |
| pay_valid | output | 1 | Forwarded payload byte available |
| pay_data | output | 8 | Forwarded payload byte |
| pay_ready | input | 1 | Downstream takes the payload byte |
| eop_valid | output | 1 | One-cycle end-of-packet pulse |
| eop_ok | output | 1 | End-of-packet status, 1 = good frame |
| ack_valid | output | 1 | One-cycle pulse: token ready to be acknowledged |
| ack_token | output | 8 | Sequence token of the good frame |
| rx_off | output | 1 | Receiver is inactive |

## Verification
The bench builds the receiver with `MTU` set to 8, keeping `PROTO_ACKREQ` and `CRC_POLY` at their defaults. With that setting a frame of five payload bytes just fits, and six or seven payload bytes reach the length abort, once on a delimiter and once on a data byte. Runs with random downstream stalls press on the output hold and back-pressure path, while frames are cut short at every header position.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   typedef enum logic [2:0] {
      RXS_OFF    = 3'd0,
      RXS_HUNT   = 3'd1,
      RXS_PROTO  = 3'd2,
      RXS_TOKEN  = 3'd3,
      RXS_BODY   = 3'd4
   } rxs_e;

endpackage

// File: rtl/hfr_crc16.sv
// Running CRC register, one byte folded per update, MSB first.
module hfr_crc16 #(
   parameter int          W    = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [7:0]   din,
   output logic [W-1:0] crc_q
);
   logic [W-1:0] step;

   always_comb begin
      step = crc_q;
      for (int i = 0; i < 8; i++) begin
         if (step[W-1] ^ din[7-i])
            step = {step[W-2:0], 1'b0} ^ POLY;
         else
            step = {step[W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '0;
      else if (clr)    crc_q <= '0;
      else if (upd)    crc_q <= step;
   end
endmodule

// File: rtl/hfr_hold2.sv
// Two-entry hold stage for body bytes plus body byte counter.
module hfr_hold2 #(
   parameter int MTU = 255,
   localparam int CW = $clog2(MTU + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [7:0]    din,
   output logic [7:0]    older,
   output logic [7:0]    newer,
   output logic          have2,
   output logic          at_limit
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older <= '0;
         newer <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (push) begin
         older <= newer;
         newer <= din;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign have2    = (cnt_q >= CW'(2));
   assign at_limit = (cnt_q >= CW'(MTU));
endmodule

// File: rtl/hfr_outreg.sv
// Single-entry payload output register with valid/ready.
module hfr_outreg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
   import hdlc_rx_pkg::*;
#(
   parameter int          MTU          = 255,
   parameter logic [7:0]  PROTO_ACKREQ = 8'h44,
   parameter logic [15:0] CRC_POLY     = 16'h1021
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       ev_valid,
   input  logic       ev_delim,
   input  logic [7:0] ev_byte,
   output logic       ev_ready,
   output logic       pay_valid,
   output logic [7:0] pay_data,
   input  logic       pay_ready,
   output logic       eop_valid,
   output logic       eop_ok,
   output logic       ack_valid,
   output logic [7:0] ack_token,
   output logic       rx_off
);
   localparam int CRCW = 16;

   generate
      if (MTU < 3 || MTU > 65535) begin : g_bad_mtu
         $error("hdlc_frame_rx: MTU must lie in 3..65535");
      end
      if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
         $error("hdlc_frame_rx: CRC polynomial must have its x^0 term set");
      end
   endgenerate

   rxs_e            st_q, st_n;
   logic            acc;
   logic            crc_clr, crc_upd, crc_from_hold;
   logic [7:0]      crc_din;
   logic [CRCW-1:0] crc_q;
   logic            hold_clr, hold_push;
   logic [7:0]      h_old, h_new;
   logic            h_two, h_lim;
   logic            fwd, fin, fin_ok, abort_f, tok_ld;
   logic [7:0]      tok_q;
   logic            fcs_match;

   assign ev_ready  = !pay_valid || pay_ready;
   assign acc       = ev_valid && ev_ready;
   assign fcs_match = (crc_q == {h_new, h_old});
   assign crc_din   = crc_from_hold ? h_old : ev_byte;

   always_comb begin
      st_n          = st_q;
      crc_clr       = 1'b0;
      crc_upd       = 1'b0;
      crc_from_hold = 1'b0;
      hold_clr      = 1'b0;
      hold_push     = 1'b0;
      fwd           = 1'b0;
      fin_ok        = 1'b0;
      abort_f       = 1'b0;
      tok_ld        = 1'b0;
      unique case (st_q)
         RXS_OFF: begin
            if (enable) st_n = RXS_HUNT;
         end
         RXS_HUNT: begin
            if (!enable) begin
               st_n = RXS_OFF;
            end else if (acc && ev_delim) begin
               st_n     = RXS_PROTO;
               crc_clr  = 1'b1;
               hold_clr = 1'b1;
            end
         end
         RXS_PROTO: begin
            if (acc && !ev_delim) begin
               if (ev_byte == PROTO_ACKREQ) begin
                  crc_upd = 1'b1;
                  st_n    = RXS_TOKEN;
               end else begin
                  abort_f = 1'b1;
               end
            end
         end
         RXS_TOKEN: begin
            if (acc) begin
               if (ev_delim) begin
                  abort_f = 1'b1;
               end else begin
                  crc_upd = 1'b1;
                  tok_ld  = 1'b1;
                  st_n    = RXS_BODY;
               end
            end
         end
         RXS_BODY: begin
            if (acc) begin
               if (h_lim) begin
                  abort_f = 1'b1;
               end else if (ev_delim) begin
                  if (h_two && fcs_match) fin_ok  = 1'b1;
                  else                    abort_f = 1'b1;
               end else begin
                  hold_push = 1'b1;
                  if (h_two) begin
                     fwd           = 1'b1;
                     crc_upd       = 1'b1;
                     crc_from_hold = 1'b1;
                  end
               end
            end
         end
         default: st_n = RXS_HUNT;
      endcase

      fin = abort_f || fin_ok;
      if (fin) begin
         crc_clr  = 1'b1;
         crc_upd  = 1'b0;
         hold_clr = 1'b1;
         if (!enable)                st_n = RXS_OFF;
         else if (abort_f && ev_delim) st_n = RXS_PROTO;
         else                        st_n = RXS_HUNT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= RXS_OFF;
         tok_q     <= '0;
         eop_valid <= 1'b0;
         eop_ok    <= 1'b0;
         ack_valid <= 1'b0;
      end else begin
         st_q      <= st_n;
         eop_valid <= fin;
         eop_ok    <= fin_ok;
         ack_valid <= fin_ok;
         if (tok_ld) tok_q <= ev_byte;
      end
   end

   assign ack_token = tok_q;
   assign rx_off    = (st_q == RXS_OFF);

   hfr_crc16 #(.W(CRCW), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .upd   (crc_upd),
      .din   (crc_din),
      .crc_q (crc_q)
   );

   hfr_hold2 #(.MTU(MTU)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (hold_clr),
      .push     (hold_push),
      .din      (ev_byte),
      .older    (h_old),
      .newer    (h_new),
      .have2    (h_two),
      .at_limit (h_lim)
   );

   hfr_outreg #(.DW(8)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fwd),
      .din   (h_old),
      .ready (pay_ready),
      .valid (pay_valid),
      .dout  (pay_data)
   );
endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       ev_valid,
   input logic       ev_delim,
   input logic       ev_ready,
   input logic       pay_valid,
   input logic [7:0] pay_data,
   input logic       pay_ready,
   input logic       eop_valid,
   input logic       eop_ok,
   input logic       ack_valid,
   input logic       rx_off
);
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> rx_off && !pay_valid && !eop_valid && !ack_valid);

   assert_fwd_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pay_valid) |-> $past(ev_valid && ev_ready && !ev_delim));

   assert_ack_on_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> eop_valid && eop_ok);

   assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid && !pay_ready |-> !ev_ready);

   assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid && !pay_ready |=> pay_valid && $stable(pay_data));

   assert_off_needs_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_off) |-> !$past(enable));

   assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_off && $past(rx_off) |-> !eop_valid && !ack_valid);
endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .ev_valid  (ev_valid),
   .ev_delim  (ev_delim),
   .ev_ready  (ev_ready),
   .pay_valid (pay_valid),
   .pay_data  (pay_data),
   .pay_ready (pay_ready),
   .eop_valid (eop_valid),
   .eop_ok    (eop_ok),
   .ack_valid (ack_valid),
   .rx_off    (rx_off)
);

// File: tb/hdlc_frame_rx_test.sv
`timescale 1ns/1ps
module hdlc_frame_rx_test;
   localparam int MTU = 8;
   localparam logic [7:0] PACK = 8'h44;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       ev_valid = 1'b0, ev_delim = 1'b0;
   logic [7:0] ev_byte = '0;
   logic       ev_ready;
   logic       pay_valid;
   logic [7:0] pay_data;
   logic       pay_ready = 1'b1;
   logic       eop_valid, eop_ok, ack_valid, rx_off;
   logic [7:0] ack_token;

   int vectors = 0, misses = 0, cycles = 0;
   string cur_req = "R1";
   bit stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int acks_seen = 0;
   logic [7:0] last_ack = '0;

   always #10 clk = ~clk;

   hdlc_frame_rx #(.MTU(MTU), .PROTO_ACKREQ(PACK)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .ev_valid(ev_valid), .ev_delim(ev_delim), .ev_byte(ev_byte), .ev_ready(ev_ready),
      .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
      .eop_valid(eop_valid), .eop_ok(eop_ok),
      .ack_valid(ack_valid), .ack_token(ack_token), .rx_off(rx_off));

   function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   task automatic chk(input string what, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         misses++;
         $display("FAIL %s %s got %0h expected %0h at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   // reference model: 0 hunt, 1 proto, 2 token, 3 body, 4 off
   int         m_st = 4, m_cnt = 0;
   logic [15:0] m_crc = '0;
   logic [7:0] hq[$];
   logic [7:0] m_tok = '0, m_acktok = '0, m_pd = '0;
   bit         m_pv = 0, m_eop = 0, m_ok = 0, m_ack = 0;

   always @(posedge clk or negedge rst_n) begin
      bit acc, ab, good;
      logic [7:0] fb;
      if (!rst_n) begin
         m_st = 4; m_cnt = 0; m_crc = '0; hq.delete();
         m_pv = 0; m_eop = 0; m_ok = 0; m_ack = 0;
      end else begin
         acc = ev_valid && (!m_pv || pay_ready);
         if (m_pv && pay_ready) m_pv = 0;
         m_eop = 0; m_ok = 0; m_ack = 0; ab = 0; good = 0;
         case (m_st)
            4: if (enable) m_st = 0;
            0: if (!enable) m_st = 4;
               else if (acc && ev_delim) begin m_st = 1; m_cnt = 0; m_crc = '0; hq.delete(); end
            1: if (acc && !ev_delim) begin
                  if (ev_byte == PACK) begin m_crc = crc_b(m_crc, ev_byte); m_st = 2; end
                  else ab = 1;
               end
            2: if (acc) begin
                  if (ev_delim) ab = 1;
                  else begin m_tok = ev_byte; m_crc = crc_b(m_crc, ev_byte); m_st = 3; end
               end
            default: if (acc) begin
                  if (m_cnt >= MTU) ab = 1;
                  else if (ev_delim) begin
                     if (m_cnt >= 2 && m_crc == {hq[1], hq[0]}) good = 1; else ab = 1;
                  end else begin
                     if (hq.size() == 2) begin
                        fb = hq.pop_front();
                        m_crc = crc_b(m_crc, fb);
                        m_pv = 1; m_pd = fb;
                     end
                     hq.push_back(ev_byte);
                     m_cnt++;
                  end
               end
         endcase
         if (ab || good) begin
            m_eop = 1; m_ok = good; m_ack = good;
            if (good) m_acktok = m_tok;
            m_cnt = 0; m_crc = '0; hq.delete();
            if (!enable) m_st = 4;
            else if (ab && ev_delim) m_st = 1;
            else m_st = 0;
         end
      end
   end

   // compare every clock, 5 ns after the edge
   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         chk("ev_ready", ev_ready, (!m_pv || pay_ready));   // R10
         chk("pay_valid", pay_valid, m_pv);                  // R5
         if (m_pv) chk("pay_data", pay_data, m_pd);          // R5 R6
         chk("eop_valid", eop_valid, m_eop);                 // R7 R8
         if (m_eop) chk("eop_ok", eop_ok, m_ok);             // R6 R7 R8
         chk("ack_valid", ack_valid, m_ack);                 // R7
         if (m_ack) chk("ack_token", ack_token, m_acktok);   // R7
         chk("rx_off", rx_off, m_st == 4);                   // R1 R11
         if (ack_valid) begin acks_seen++; last_ack = ack_token; end
      end
   end

   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pay_ready = stall_en ? lfsr[0] : 1'b1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         misses++;
         $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   task automatic put(input bit d, input logic [7:0] b);
      bit ok;
      ok = 0;
      while (!ok) begin
         @(negedge clk);
         ev_valid = 1'b1; ev_delim = d; ev_byte = b;
         #1 ok = ev_ready;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ev_valid = 1'b0;
      end
   endtask

   task automatic frame(input logic [7:0] proto, input logic [7:0] tok, input int n,
                        input logic [7:0] seed, input bit corrupt);
      logic [15:0] c;
      logic [7:0]  b;
      c = crc_b(16'h0000, proto);
      c = crc_b(c, tok);
      put(1, 8'h7E); put(0, proto); put(0, tok);
      for (int i = 0; i < n; i++) begin
         b = seed + 8'(i * 37);
         c = crc_b(c, b);
         put(0, b);
      end
      if (corrupt) c = c ^ 16'h0100;
      put(0, c[7:0]); put(0, c[15:8]); put(1, 8'h7E);
   endtask

   initial begin
      // R1: reset state seen at the ports
      #15;
      cur_req = "R1";
      chk("rx_off in reset", rx_off, 1);
      chk("pay_valid in reset", pay_valid, 0);
      chk("eop_valid in reset", eop_valid, 0);
      chk("ev_ready in reset", ev_ready, 1);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      enable = 1'b1;
      put(0, 8'h12); put(0, PACK); put(0, 8'h33);      // R1: ignored in no-sync
      idle(2);

      cur_req = "R2";                                    // extra delimiters before protocol byte
      put(1, 0); put(1, 0); put(1, 0);
      cur_req = "R7";
      frame(PACK, 8'h5A, 3, 8'h10, 0);
      idle(3);
      chk("R7 ack count", acks_seen, 1);
      chk("R7 ack token", last_ack, 8'h5A);

      cur_req = "R6";                                    // longest frame that fits
      frame(PACK, 8'hC3, 5, 8'hF0, 0);
      frame(PACK, 8'h01, 0, 8'h00, 0);                   // header plus FCS only
      idle(2);

      cur_req = "R3";                                    // wrong protocol byte
      frame(8'h45, 8'h22, 2, 8'h40, 0);
      frame(PACK, 8'h23, 2, 8'h41, 0);
      idle(2);

      cur_req = "R4";                                    // delimiter in place of token
      put(1, 0); put(0, PACK); put(1, 0);
      put(0, PACK); put(0, 8'h66); put(0, 8'h00); put(0, 8'h00); put(1, 0);
      frame(PACK, 8'h67, 1, 8'h99, 0);
      idle(2);

      cur_req = "R8";                                    // bad FCS, then short bodies
      frame(PACK, 8'h70, 3, 8'h21, 1);
      put(0, PACK); put(0, 8'h71); put(0, 8'hAB); put(1, 0);
      put(0, PACK); put(0, 8'h72); put(1, 0);
      idle(2);

      cur_req = "R9";                                    // length limit on delimiter and on data
      frame(PACK, 8'h80, 6, 8'h05, 0);
      frame(PACK, 8'h81, 7, 8'h06, 0);
      frame(PACK, 8'h82, 2, 8'h07, 0);
      idle(2);

      cur_req = "R10";                                   // random downstream stalls
      stall_en = 1'b1;
      for (int k = 0; k < 12; k++) frame(PACK, 8'(8'h90 + k), (k % 6), 8'(k * 11), (k % 5) == 4);
      stall_en = 1'b0;
      idle(3);

      cur_req = "R11";                                   // stop in the middle of a frame
      put(1, 0); put(0, PACK); put(0, 8'hA1); put(0, 8'h11);
      enable = 1'b0;
      put(0, 8'h22); put(0, 8'h33); put(1, 0);
      put(1, 0); put(0, PACK); put(0, 8'h44);           // ignored while inactive
      idle(3);
      chk("R11 inactive", rx_off, 1);
      enable = 1'b1;
      idle(2);
      chk("R11 resumed", rx_off, 0);
      frame(PACK, 8'hB2, 2, 8'h31, 0);
      enable = 1'b0;                                     // stop straight from no-sync
      idle(3);
      chk("R11 stop from no-sync", rx_off, 1);
      idle(2);
      chk("R7 total acks", acks_seen, 17);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule